// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the combinational arithmetic and logic stage of a small load/store processor. Each evaluation takes a first source value, a second source that is either a register value shifted left by a small amount or a short unsigned immediate, a 4-bit operation code, a set-flags control and the current condition flags. It returns a result word and the next value of the condition flags. The flag state lives outside the block: the caller feeds the present flags in and stores whatever comes out.

The operation set covers plain and carry-chained addition, forward and reverse subtraction with and without the incoming carry, the four bitwise operations including bit-clear, and the two move forms. All arithmetic is done by one adder fed with a prepared pair of operands, so the carry and signed-overflow flags come from a single place. Flags move only when software asks for them. The logical and move operations never touch carry or overflow.

Top module: `dp_alu`

## Requirements
- R1: Code 0 gives a+b and code 1 gives a+b+C, where C is flags_in[1]. Carry-out goes to C.
- R2: Code 2 gives a-b and code 3 gives a-b+C-1. C out is set when no borrow occurred.
- R3: Code 4 gives b-a and code 5 gives b-a+C-1. C out is set when no borrow occurred.
- R4: Code 6 gives a AND b, code 7 gives a OR b, code 8 gives a XOR b and code 9 gives a AND NOT b.
- R5: Code 10 passes b to the result. Code 11 passes NOT b, so operand zero yields 0xFFFFFFFF.
- R6: With use_imm=1, operand b is the 8-bit b_imm zero-extended, and b_shamt has no effect. With use_imm=0, operand b is b_reg shifted left logically by b_shamt.
- R7: The flags use bit 3 for N, bit 2 for Z, bit 1 for C and bit 0 for V. On an update, N is result bit 31 and Z is set only for an all-zero result.
- R8: On an arithmetic update, V is the signed overflow of the addition actually performed.
- R9: With set_flags=0, flags_out equals flags_in for every code, and the result is still produced.
- R10: Codes 6 to 11 with set_flags=1 update only N and Z. C and V are copied from flags_in.
- R11: Codes 12 to 15 give a zero result and leave flags_out equal to flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First source operand |
| b_reg | input | 32 | Register form of the second operand |
| b_imm | input | 8 | Immediate form of the second operand |
| use_imm | input | 1 | 1 selects the immediate, 0 selects the shifted register |
| b_shamt | input | 2 | Left-shift amount applied to b_reg |
| op | input | 4 | Operation code |
| set_flags | input | 1 | 1 lets the operation update the flags |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The block holds no state, so any internal fault shows at result or flags_out in the same evaluation that triggers it. Examples are a wrong operand swap in the reverse subtracts, a carry-in taken from the wrong flag bit, and a mask applied to C and V. The vectors therefore include the cases where each fault changes a visible bit: borrow and no-borrow, signed overflow in both directions, zero results, and set flags fed into logical operations. A fault in the second-operand path shows as a result that is off by a shift or an extension.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_RSB = 4'd4,
      OP_RSC = 4'd5,
      OP_AND = 4'd6,
      OP_ORR = 4'd7,
      OP_EOR = 4'd8,
      OP_BIC = 4'd9,
      OP_MOV = 4'd10,
      OP_MVN = 4'd11
   } op_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;

   function automatic logic op_is_arith(input logic [3:0] code);
      return code <= 4'd5;
   endfunction

   function automatic logic op_is_logic(input logic [3:0] code);
      return (code >= 4'd6) && (code <= 4'd11);
   endfunction

endpackage

// File: rtl/dp_opnd_b.sv
module dp_opnd_b #(
   parameter int WIDTH = 32,
   parameter int IMM_W = 8,
   parameter int SH_W  = 2
) (
   input  logic [WIDTH-1:0] b_reg,
   input  logic [IMM_W-1:0] b_imm,
   input  logic             use_imm,
   input  logic [SH_W-1:0]  b_shamt,
   output logic [WIDTH-1:0] opb
);
   localparam int PAD_W = WIDTH - IMM_W;

   logic [WIDTH-1:0] imm_ext;
   logic [WIDTH-1:0] reg_shl;

   generate
      if (PAD_W > 0) begin : g_pad
         assign imm_ext = {{PAD_W{1'b0}}, b_imm};
      end else begin : g_nopad
         assign imm_ext = b_imm[WIDTH-1:0];
      end
   endgenerate

   assign reg_shl = b_reg << b_shamt;
   assign opb     = use_imm ? imm_ext : reg_shl;
endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
   parameter int WIDTH  = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]  = x[i] ^ y[i] ^ cy[i];
            assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
         end
         assign cout = cy[WIDTH];
         assign ovf  = cy[WIDTH] ^ cy[WIDTH-1];
      end else begin : g_fast
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
         assign ovf  = (x[WIDTH-1] == y[WIDTH-1]) && (sum[WIDTH-1] != x[WIDTH-1]);
      end
   endgenerate
endmodule

// File: rtl/dp_logic.sv
module dp_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [3:0]       op,
   output logic [WIDTH-1:0] res
);
   import dp_alu_pkg::*;

   always_comb begin
      case (op)
         OP_AND:  res = a & b;
         OP_ORR:  res = a | b;
         OP_EOR:  res = a ^ b;
         OP_BIC:  res = a & ~b;
         OP_MOV:  res = b;
         OP_MVN:  res = ~b;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
   parameter int WIDTH  = 32,
   parameter int IMM_W  = 8,
   parameter int SH_W   = 2,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b_reg,
   input  logic [IMM_W-1:0] b_imm,
   input  logic             use_imm,
   input  logic [SH_W-1:0]  b_shamt,
   input  logic [3:0]       op,
   input  logic             set_flags,
   input  logic [3:0]       flags_in,
   output logic [WIDTH-1:0] result,
   output logic [3:0]       flags_out
);
   import dp_alu_pkg::*;

   localparam int MAX_SH = (1 << SH_W) - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("dp_alu: WIDTH must be at least 2");
      end
      if (IMM_W > WIDTH) begin : g_bad_imm
         $error("dp_alu: IMM_W must not exceed WIDTH");
      end
      if (MAX_SH >= WIDTH) begin : g_bad_sh
         $error("dp_alu: SH_W allows shifts of the full width");
      end
   endgenerate

   logic [WIDTH-1:0] opb;
   logic [WIDTH-1:0] add_x, add_y, add_sum, log_res;
   logic             add_cin, add_cout, add_ovf;
   logic             c_now;
   logic             is_arith, is_logic;

   dp_opnd_b #(.WIDTH(WIDTH), .IMM_W(IMM_W), .SH_W(SH_W)) u_opnd (
      .b_reg   (b_reg),
      .b_imm   (b_imm),
      .use_imm (use_imm),
      .b_shamt (b_shamt),
      .opb     (opb)
   );

   assign c_now    = flags_in[FLAG_C];
   assign is_arith = op_is_arith(op);
   assign is_logic = op_is_logic(op);

   always_comb begin
      add_x   = a;
      add_y   = opb;
      add_cin = 1'b0;
      case (op)
         OP_ADC: add_cin = c_now;
         OP_SUB: begin add_y = ~opb; add_cin = 1'b1;  end
         OP_SBC: begin add_y = ~opb; add_cin = c_now; end
         OP_RSB: begin add_x = opb; add_y = ~a; add_cin = 1'b1;  end
         OP_RSC: begin add_x = opb; add_y = ~a; add_cin = c_now; end
         default: ;
      endcase
   end

   dp_addsub #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (add_sum),
      .cout (add_cout),
      .ovf  (add_ovf)
   );

   dp_logic #(.WIDTH(WIDTH)) u_logic (
      .a   (a),
      .b   (opb),
      .op  (op),
      .res (log_res)
   );

   always_comb begin
      if (is_arith)      result = add_sum;
      else if (is_logic) result = log_res;
      else               result = '0;
   end

   always_comb begin
      flags_out = flags_in;
      if (set_flags && (is_arith || is_logic)) begin
         flags_out[FLAG_N] = result[WIDTH-1];
         flags_out[FLAG_Z] = (result == '0);
         if (is_arith) begin
            flags_out[FLAG_C] = add_cout;
            flags_out[FLAG_V] = add_ovf;
         end
      end
   end
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
   parameter int WIDTH  = 32,
   parameter int IMM_W  = 8,
   parameter int SH_W   = 2,
   parameter bit RIPPLE = 1'b0
) (
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b_reg,
   input logic [IMM_W-1:0] b_imm,
   input logic             use_imm,
   input logic [SH_W-1:0]  b_shamt,
   input logic [3:0]       op,
   input logic             set_flags,
   input logic [3:0]       flags_in,
   input logic [WIDTH-1:0] result,
   input logic [3:0]       flags_out
);
   always_comb begin
      // R9
      if (!set_flags) flags_hold_chk: assert (flags_out == flags_in);
      // R11
      if (op >= 4'd12) unused_op_chk: assert (result == '0 && flags_out == flags_in);
      // R10
      if (op >= 4'd6 && op <= 4'd11) logic_cv_chk: assert (flags_out[1:0] == flags_in[1:0]);
      // R7
      if (set_flags && op <= 4'd11) zero_flag_chk: assert (flags_out[2] == (result == '0));
      // R7
      if (set_flags && op <= 4'd11) neg_flag_chk: assert (flags_out[3] == result[WIDTH-1]);
      // R5
      if (op == 4'd11 && use_imm && b_imm == '0) mvn_zero_chk: assert (&result);
   end
endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W), .SH_W(SH_W), .RIPPLE(RIPPLE)) u_chk (.*);

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 20;

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic        isel;
      logic [7:0]  imm;
      logic [1:0]  sh;
      logic [3:0]  op;
      logic        sf;
      logic [3:0]  fin;
      logic [31:0] er;
      logic [3:0]  ef;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{32'd1, 32'd2, 1'b0, 8'h00, 2'd0, 4'd0, 1'b1, 4'h0, 32'd3, 4'h0, 4'd1},                    // R1
      '{32'hFFFFFFFF, 32'd1, 1'b0, 8'h00, 2'd0, 4'd0, 1'b1, 4'h0, 32'd0, 4'h6, 4'd1},             // R1
      '{32'h7FFFFFFF, 32'd1, 1'b0, 8'h00, 2'd0, 4'd0, 1'b1, 4'h0, 32'h80000000, 4'h9, 4'd8},      // R8
      '{32'd5, 32'd3, 1'b0, 8'h00, 2'd0, 4'd1, 1'b1, 4'h2, 32'd9, 4'h0, 4'd1},                    // R1
      '{32'd5, 32'd5, 1'b0, 8'h00, 2'd0, 4'd2, 1'b1, 4'h0, 32'd0, 4'h6, 4'd2},                    // R2
      '{32'd3, 32'd5, 1'b0, 8'h00, 2'd0, 4'd2, 1'b1, 4'h0, 32'hFFFFFFFE, 4'h8, 4'd2},             // R2
      '{32'd10, 32'd3, 1'b0, 8'h00, 2'd0, 4'd3, 1'b1, 4'h0, 32'd6, 4'h2, 4'd2},                   // R2
      '{32'd3, 32'd10, 1'b0, 8'h00, 2'd0, 4'd4, 1'b1, 4'h0, 32'd7, 4'h2, 4'd3},                   // R3
      '{32'd3, 32'd10, 1'b0, 8'h00, 2'd0, 4'd5, 1'b1, 4'h0, 32'd6, 4'h2, 4'd3},                   // R3
      '{32'h69, 32'hC7, 1'b0, 8'h00, 2'd0, 4'd6, 1'b1, 4'h3, 32'h41, 4'h3, 4'd10},                // R10
      '{32'h69, 32'hC7, 1'b0, 8'h00, 2'd0, 4'd7, 1'b1, 4'h0, 32'hEF, 4'h0, 4'd4},                 // R4
      '{32'h69, 32'hC7, 1'b0, 8'h00, 2'd0, 4'd8, 1'b1, 4'h0, 32'hAE, 4'h0, 4'd4},                 // R4
      '{32'h69, 32'hC7, 1'b0, 8'h00, 2'd0, 4'd9, 1'b1, 4'h0, 32'h28, 4'h0, 4'd4},                 // R4
      '{32'h0, 32'h0, 1'b0, 8'h00, 2'd0, 4'd11, 1'b1, 4'h0, 32'hFFFFFFFF, 4'h8, 4'd5},            // R5
      '{32'h0, 32'h1234, 1'b1, 8'hFF, 2'd0, 4'd10, 1'b1, 4'h0, 32'hFF, 4'h0, 4'd6},               // R6
      '{32'd1, 32'd3, 1'b0, 8'h00, 2'd2, 4'd0, 1'b1, 4'h0, 32'd13, 4'h0, 4'd6},                   // R6
      '{32'h0, 32'h0, 1'b0, 8'h00, 2'd0, 4'd0, 1'b0, 4'hF, 32'd0, 4'hF, 4'd9},                    // R9
      '{32'h5, 32'h6, 1'b0, 8'h00, 2'd0, 4'd12, 1'b1, 4'h5, 32'd0, 4'h5, 4'd11},                  // R11
      '{32'hF0, 32'h0F, 1'b0, 8'h00, 2'd0, 4'd6, 1'b1, 4'h0, 32'd0, 4'h4, 4'd7},                  // R7
      '{32'h80000000, 32'd1, 1'b0, 8'h00, 2'd0, 4'd2, 1'b1, 4'h0, 32'h7FFFFFFF, 4'h3, 4'd8}       // R8
   };

   logic        clk = 1'b0;
   logic [31:0] a, b_reg;
   logic [7:0]  b_imm;
   logic        use_imm;
   logic [1:0]  b_shamt;
   logic [3:0]  op;
   logic        set_flags;
   logic [3:0]  flags_in;
   logic [31:0] result;
   logic [3:0]  flags_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dp_alu u_dut (
      .a(a), .b_reg(b_reg), .b_imm(b_imm), .use_imm(use_imm), .b_shamt(b_shamt),
      .op(op), .set_flags(set_flags), .flags_in(flags_in),
      .result(result), .flags_out(flags_out)
   );

   task automatic drive(input vec_t v);
      @(negedge clk);
      a = v.a; b_reg = v.b; use_imm = v.isel; b_imm = v.imm; b_shamt = v.sh;
      op = v.op; set_flags = v.sf; flags_in = v.fin;
      #1;
   endtask

   task automatic check(input int req, input logic [31:0] er, input logic [3:0] ef);
      checks++;
      if (result !== er || flags_out !== ef) begin
         errors++;
         $display("FAIL R%0d: result=%h flags=%b expected result=%h flags=%b",
                  req, result, flags_out, er, ef);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      vec_t d;
      repeat (2) @(posedge clk);
      // idle state: all-zero inputs with flags held
      d = '{32'h0, 32'h0, 1'b0, 8'h0, 2'd0, 4'd0, 1'b0, 4'h0, 32'h0, 4'h0, 4'd9};
      drive(d); check(9, 32'h0, 4'h0);   // R9

      for (int i = 0; i < NVEC; i++) begin
         drive(VECS[i]);
         check(int'(VECS[i].req), VECS[i].er, VECS[i].ef);
      end

      // R6: immediate is zero-extended and the shift amount has no effect on it
      d = '{32'h0, 32'hFFFF_FFFF, 1'b1, 8'h80, 2'd3, 4'd10, 1'b1, 4'h0, 32'h80, 4'h0, 4'd6};
      drive(d); check(6, 32'h80, 4'h0);
      // R6: largest register shift
      d = '{32'h0, 32'h4000_0001, 1'b0, 8'h0, 2'd3, 4'd10, 1'b1, 4'h0, 32'h8, 4'h0, 4'd6};
      drive(d); check(6, 32'h8, 4'h0);
      // R10: MVN with C,V set keeps them, N set
      d = '{32'h0, 32'h0, 1'b1, 8'h00, 2'd0, 4'd11, 1'b1, 4'h3, 32'hFFFFFFFF, 4'hB, 4'd10};
      drive(d); check(10, 32'hFFFFFFFF, 4'hB);
      // R9: subtract with flags disabled still yields the difference
      d = '{32'd9, 32'd4, 1'b0, 8'h00, 2'd0, 4'd2, 1'b0, 4'hA, 32'd5, 4'hA, 4'd9};
      drive(d); check(9, 32'd5, 4'hA);
      // R11: highest unused code
      d = '{32'hFF, 32'hFF, 1'b0, 8'h00, 2'd0, 4'd15, 1'b1, 4'h9, 32'd0, 4'h9, 4'd11};
      drive(d); check(11, 32'd0, 4'h9);
      // R3: reverse subtract with carry set and a borrow, result negative
      d = '{32'd10, 32'd3, 1'b0, 8'h00, 2'd0, 4'd5, 1'b1, 4'h2, 32'hFFFFFFF9, 4'h8, 4'd3};
      drive(d); check(3, 32'hFFFFFFF9, 4'h8);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule